// File: doc/BRIEF.md
# Calendar Alarm Comparator with Per-Field Enables

This block watches a running calendar held in BCD and raises an alarm when the calendar reaches a programmed moment. Six alarm registers hold target values for seconds, minutes, hours, weekday, day of month and month. Each register carries its own compare-enable in its top bit. Only the fields whose enable is set take part in the comparison, so an alarm can fire every minute at a given second, every day at a given time, or on a given weekday, from the same hardware.

The calendar counters sit outside the block. They present the current BCD fields and pulse a one-cycle seconds strobe each time the calendar advances. The comparison runs on that strobe only. A hit sets a sticky alarm flag in a control register. The interrupt output is a level that is high while the flag and the alarm interrupt enable are both set. Software uses a simple byte register port to program the alarm registers, to read them back, to enable the interrupt and to clear the flag.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset every alarm register reads 0x00, the control register reads 0x00 and `alarm_irq` is low.
- R2: Alarm registers sit at addresses 8 to 13 in the order seconds, minutes, hours, weekday, day, month. A read returns the byte exactly as written: bit 7 is the compare enable and bits 6:0 are the BCD compare value.
- R3: The control register is at address 14. Bit 0 reads the alarm flag, bit 3 reads and writes the alarm interrupt enable, and all other bits read 0. Any address outside 8 to 14 reads 0x00 and ignores writes.
- R4: When `sec_tick` is high and every enabled field's value equals bits 6:0 of the matching current-time input, the alarm flag reads 1 from the next clock cycle.
- R5: A field whose enable bit is 0 is left out of the comparison. A mismatch in that field does not stop a match.
- R6: When no field is enabled, for example after all six registers are written 0x00, the flag never sets.
- R7: Without `sec_tick` the flag does not set, even when the current time matches.
- R8: The flag is sticky. It stays set until software writes the control register with bit 0 at 0. Writing bit 0 as 1 never sets it.
- R9: When a clearing write and a matching tick fall in the same cycle, the flag ends set.
- R10: `alarm_irq` is high exactly when the flag and the interrupt enable are both 1. It is a level, not a pulse.
- R11: Bit 7 of each current-time input takes no part in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle strobe; the calendar has just advanced |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_wday | input | 8 | Current weekday, BCD |
| now_day | input | 8 | Current day of month, BCD |
| now_mon | input | 8 | Current month, BCD 1 to 12 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| alarm_irq | output | 1 | Alarm interrupt level |

## Verification
The properties assume that `sec_tick` lasts one cycle and that the calendar inputs are steady in the cycle it is high. They also assume that the only way to clear the flag is a control write with bit 0 at 0. The bench changes the time inputs and the alarm registers only when no tick is pending. It raises the tick for exactly one cycle. It sets bit 7 of every time input to 1, so a compare that wrongly includes that bit shows up as a missed match. The enable masks are swept over all 64 values, and each mask is tried with a full match, a mismatch in a disabled field and a mismatch in an enabled field.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

    localparam int NUM_FIELDS = 6;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 8;
    localparam int VAL_W      = DATA_W - 1;
    localparam int IDX_W      = $clog2(NUM_FIELDS);
    localparam int ALARM_BASE = 8;
    localparam int CTRL_ADDR  = ALARM_BASE + NUM_FIELDS;
    localparam int FLAG_BIT   = 0;
    localparam int AIE_BIT    = 3;

    typedef struct packed {
        logic             en;
        logic [VAL_W-1:0] val;
    } alarm_field_t;

    typedef enum logic [IDX_W-1:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_WDAY = 3'd3,
        FLD_DAY  = 3'd4,
        FLD_MON  = 3'd5
    } field_e;

    function automatic logic is_alarm_addr(input logic [ADDR_W-1:0] a);
        return (a >= ADDR_W'(ALARM_BASE)) && (a < ADDR_W'(CTRL_ADDR));
    endfunction

    function automatic logic [IDX_W-1:0] field_of(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] off;
        off = a - ADDR_W'(ALARM_BASE);
        return off[IDX_W-1:0];
    endfunction

    function automatic logic is_ctrl_addr(input logic [ADDR_W-1:0] a);
        return a == ADDR_W'(CTRL_ADDR);
    endfunction

endpackage

// File: rtl/alarm_regbank.sv
module alarm_regbank
    import cal_alarm_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    output alarm_field_t [NUM_FIELDS-1:0]     fields
);

    logic                 sel_alarm;
    logic [IDX_W-1:0]     sel_idx;

    assign sel_alarm = is_alarm_addr(addr);
    assign sel_idx   = field_of(addr);

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst) begin
                fields[g] <= '0;
            end else if (we && sel_alarm && (sel_idx == IDX_W'(g))) begin
                fields[g] <= alarm_field_t'(wdata);
            end
        end
    end

endmodule

// File: rtl/field_match.sv
module field_match
    import cal_alarm_pkg::*;
(
    input  alarm_field_t [NUM_FIELDS-1:0]             fields,
    input  logic [NUM_FIELDS-1:0][VAL_W-1:0]          now_val,
    output logic                                      hit,
    output logic                                      any_en
);

    logic [NUM_FIELDS-1:0] field_ok;
    logic [NUM_FIELDS-1:0] en_vec;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
        assign en_vec[g]   = fields[g].en;
        assign field_ok[g] = !fields[g].en || (fields[g].val == now_val[g]);
    end

    assign any_en = |en_vec;
    assign hit    = any_en && (&field_ok);

endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              hit,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              flag,
    output logic              aie
);

    logic ctrl_wr;
    logic clear_req;
    logic set_req;

    assign ctrl_wr   = we && is_ctrl_addr(addr);
    assign clear_req = ctrl_wr && !wdata[FLAG_BIT];
    assign set_req   = tick && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_req) begin
            flag <= 1'b1;
        end else if (clear_req) begin
            flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aie <= 1'b0;
        end else if (ctrl_wr) begin
            aie <= wdata[AIE_BIT];
        end
    end

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic [7:0]        now_sec,
    input  logic [7:0]        now_min,
    input  logic [7:0]        now_hour,
    input  logic [7:0]        now_wday,
    input  logic [7:0]        now_day,
    input  logic [7:0]        now_mon,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              alarm_irq
);

    alarm_field_t [NUM_FIELDS-1:0]        fields;
    logic [NUM_FIELDS-1:0][VAL_W-1:0]     now_val;
    logic                                 hit;
    logic                                 any_en;
    logic                                 alarm_flag;
    logic                                 alarm_ie;

    always_comb begin
        now_val[FLD_SEC]  = now_sec[VAL_W-1:0];
        now_val[FLD_MIN]  = now_min[VAL_W-1:0];
        now_val[FLD_HOUR] = now_hour[VAL_W-1:0];
        now_val[FLD_WDAY] = now_wday[VAL_W-1:0];
        now_val[FLD_DAY]  = now_day[VAL_W-1:0];
        now_val[FLD_MON]  = now_mon[VAL_W-1:0];
    end

    alarm_regbank u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .fields (fields)
    );

    field_match u_match (
        .fields  (fields),
        .now_val (now_val),
        .hit     (hit),
        .any_en  (any_en)
    );

    alarm_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .tick  (sec_tick),
        .hit   (hit),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .flag  (alarm_flag),
        .aie   (alarm_ie)
    );

    always_comb begin
        bus_rdata = '0;
        if (is_alarm_addr(bus_addr)) begin
            bus_rdata = fields[field_of(bus_addr)];
        end else if (is_ctrl_addr(bus_addr)) begin
            bus_rdata[FLAG_BIT] = alarm_flag;
            bus_rdata[AIE_BIT]  = alarm_ie;
        end
    end

    assign alarm_irq = alarm_flag && alarm_ie;

endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk
    import cal_alarm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sec_tick,
    input logic              hit,
    input logic              any_en,
    input logic              alarm_flag,
    input logic              alarm_irq,
    input logic              bus_we,
    input logic [3:0]        bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata
);

    logic clr_wr;
    assign clr_wr = bus_we && (bus_addr == 4'(CTRL_ADDR)) && !bus_wdata[FLAG_BIT];

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!alarm_flag && !alarm_irq)); // R1

    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && hit) |=> alarm_flag); // R4

    AST_NONE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !any_en && !alarm_flag) |=> !alarm_flag); // R6

    AST_NO_TICK_NO_SET: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !alarm_flag) |=> !alarm_flag); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !clr_wr) |=> alarm_flag); // R8

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 4'(CTRL_ADDR)) |->
            (alarm_irq == (bus_rdata[FLAG_BIT] && bus_rdata[AIE_BIT]))); // R10

endmodule

bind cal_alarm_match cal_alarm_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sec_tick   (sec_tick),
    .hit        (hit),
    .any_en     (any_en),
    .alarm_flag (alarm_flag),
    .alarm_irq  (alarm_irq),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata)
);

// File: tb/cal_alarm_match_tb.sv
`timescale 1ns/1ps
module cal_alarm_match_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic [7:0] now_v [6];
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       alarm_irq;

    int checks = 0;
    int bad    = 0;
    bit done   = 0;

    localparam logic [7:0] ALM_VAL [6] = '{8'h45, 8'h30, 8'h23, 8'h06, 8'h31, 8'h12};

    always #2.5 clk = ~clk;

    cal_alarm_match u_dut (
        .clk       (clk),
        .rst       (rst),
        .sec_tick  (sec_tick),
        .now_sec   (now_v[0]),
        .now_min   (now_v[1]),
        .now_hour  (now_v[2]),
        .now_wday  (now_v[3]),
        .now_day   (now_v[4]),
        .now_mon   (now_v[5]),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .alarm_irq (alarm_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 6; i++) now_v[i] = ALM_VAL[i] | 8'h80;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 8; a <= 14; a++) begin
            rd(4'(a), d); check("R1 reset reg", d, 8'h00);
        end
        check("R1 reset irq", {7'd0, alarm_irq}, 8'h00);

        // R2: readback per address
        for (int i = 0; i < 6; i++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] pat;
                pat = (p == 0) ? 8'h80 : (p == 1) ? 8'hFF : (p == 2) ? 8'h5A : 8'(8'h11 * (i + 1));
                wr(4'(8 + i), pat);
                rd(4'(8 + i), d); check("R2 readback", d, pat);
            end
        end
        for (int i = 0; i < 6; i++) wr(4'(8 + i), 8'h00);

        // R3: control bits and unmapped addresses
        wr(4'd14, 8'hFF);
        rd(4'd14, d); check("R3 ctrl write ff", d, 8'h08);
        wr(4'd7, 8'hFF);  rd(4'd7, d);  check("R3 unmapped 7", d, 8'h00);
        wr(4'd15, 8'hFF); rd(4'd15, d); check("R3 unmapped 15", d, 8'h00);
        wr(4'd0, 8'hFF);  rd(4'd0, d);  check("R3 unmapped 0", d, 8'h00);
        for (int i = 0; i < 6; i++) begin
            rd(4'(8 + i), d); check("R3 unmapped write ignored", d, 8'h00);
        end

        // R6: no field enabled, time matches values
        pulse_tick();
        rd(4'd14, d); check("R6 none enabled", d, 8'h08);

        // Sweep of all enable masks: R4 R5 R11 R10
        for (int m = 0; m < 64; m++) begin
            for (int c = 0; c < 3; c++) begin
                bit exp;
                int j;
                wr(4'd14, 8'h08);
                for (int i = 0; i < 6; i++) begin
                    wr(4'(8 + i), ALM_VAL[i] | (m[i] ? 8'h80 : 8'h00));
                    now_v[i] = ALM_VAL[i] | 8'h80;
                end
                j = -1;
                for (int i = 0; i < 6; i++) begin
                    if (j < 0 && ((c == 1 && !m[i]) || (c == 2 && m[i]))) j = i;
                end
                if (j >= 0) now_v[j] = now_v[j] ^ 8'h01;
                exp = (m != 0) && !(c == 2 && j >= 0);
                pulse_tick();
                rd(4'd14, d);
                check(c == 1 ? "R5 disabled mismatch" : (m == 0 ? "R6 mask zero" : "R4 R11 match"), d, {4'd0, 1'b1, 2'd0, exp});
                check("R10 irq level", {7'd0, alarm_irq}, {7'd0, exp});
            end
        end

        // R7: matching time but no tick
        wr(4'd14, 8'h08);
        for (int i = 0; i < 6; i++) begin
            wr(4'(8 + i), ALM_VAL[i] | 8'h80);
            now_v[i] = ALM_VAL[i];
        end
        repeat (5) @(negedge clk);
        rd(4'd14, d); check("R7 no tick", d, 8'h08);

        // R8: sticky, write 1 keeps, write 0 clears
        pulse_tick();
        now_v[0] = 8'h00;
        pulse_tick();
        repeat (3) @(negedge clk);
        rd(4'd14, d); check("R8 sticky", d, 8'h09);
        wr(4'd14, 8'h09);
        rd(4'd14, d); check("R8 write one keeps", d, 8'h09);
        wr(4'd14, 8'h08);
        rd(4'd14, d); check("R8 write zero clears", d, 8'h08);
        wr(4'd14, 8'h01);
        rd(4'd14, d); check("R8 write one no set", d, 8'h00);

        // R10: flag set, enable off then on
        now_v[0] = ALM_VAL[0];
        pulse_tick();
        rd(4'd14, d); check("R10 flag no enable", d, 8'h01);
        check("R10 irq low", {7'd0, alarm_irq}, 8'h00);
        wr(4'd14, 8'h09);
        check("R10 irq high", {7'd0, alarm_irq}, 8'h01);

        // R9: clear and match in the same cycle
        @(negedge clk);
        sec_tick = 1'b1; bus_we = 1'b1; bus_addr = 4'd14; bus_wdata = 8'h08;
        @(negedge clk);
        sec_tick = 1'b0; bus_we = 1'b0;
        rd(4'd14, d); check("R9 clear vs match", d, 8'h09);

        // R1: reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(4'd14, d); check("R1 reset again ctrl", d, 8'h00);
        rd(4'd8, d);  check("R1 reset again alarm", d, 8'h00);
        check("R1 reset again irq", {7'd0, alarm_irq}, 8'h00);

        finish_run();
    end

endmodule